// File: doc/BRIEF.md
# Overlapping 0-1-1-1-0 Pattern Detector

This block watches a single-bit serial line and raises a flag each time the five most recent samples, oldest first, read 0, 1, 1, 1, 0. Samples are taken at a slow rate set by a one-cycle enable. The enable comes from a prescaler counter that runs on the fast system clock, so the whole block uses one clock and no derived clock. Matches may overlap: the closing zero of one match also counts as the opening zero of the next.

When a match lands, the flag stays high for a fixed number of sample periods, two by default. If a new match arrives during that window, the window starts again. A debug probe bus shows the current state as a one-hot code, together with the sample enable, the flag and the reset. The reset is synchronous and active high, and is meant to be driven from a push button that has already been synchronised.

Top module: `pattern_watch`

## Requirements
- R1: `probe_o[5]` is the sample enable. After reset it is high for exactly one clock cycle in every DIV cycles. The first pulse comes in the DIV-th cycle after reset is released.
- R2: `din` is sampled only in cycles where the enable is high. The state and `match_o` do not change in any other cycle.
- R3: The states are Idle, Z, Z1, Z11 and Z111. Their transitions on a sample are: Idle goes to Z on 0 and stays on 1. Z stays on 0 and goes to Z1 on 1. Z1 goes to Z11 on 1. Z11 goes to Z111 on 1. Z1 and Z11 go back to Z on 0. Z111 goes to Idle on 1.
- R4: A sample of 0 taken in state Z111 is a match, and the next state is Z. The stream 011101110 therefore gives two matches.
- R5: `match_o` rises in the cycle after the matching sample. With HOLD_TICKS=2 it falls in the cycle after the second later sample.
- R6: A match that arrives while `match_o` is held restarts the full HOLD_TICKS window, so the flag stays high without a gap.
- R7: While `rst_btn` is high at a clock edge, the prescaler count clears, the state goes to Idle and `match_o` goes low.
- R8: `probe_o[4:0]` is the one-hot state, with bit 0 = Idle, bit 1 = Z, bit 2 = Z1, bit 3 = Z11 and bit 4 = Z111. Bit 6 is `match_o` and bit 7 is `rst_btn`.
- R9: A stream that repeats 0111 gives one match per repetition once the first full pattern has arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_btn | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| match_o | output | 1 | Held detection flag |
| probe_o | output | 8 | Debug probe: state, enable, flag, reset |

## Verification
The hardest case to reach is a second match landing while the flag is still held. Overlapping matches are at least four samples apart, so with the default two-sample hold this case cannot occur. The bench therefore drives the same stream into a second instance whose hold is six samples. For that instance the flag must stay high from the first match until six samples after the second one. The sample-only-on-enable rule is checked by toggling `din` in every cycle between enables and watching the state stay put.

// File: rtl/pattern_watch_pkg.sv
package pattern_watch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_Z    = 3'd1,
        ST_Z1   = 3'd2,
        ST_Z11  = 3'd3,
        ST_Z111 = 3'd4
    } pw_state_e;

    localparam int NUM_STATES = 5;

endpackage

// File: rtl/pw_tick_gen.sv
module pw_tick_gen #(
    parameter int DIV = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.cnt == LAST) begin
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
        if (rst) begin
            nxt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign tick = (cur_q.cnt == LAST) && !rst;

    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
    import pattern_watch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  din,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  hit
);
    typedef struct packed {
        pw_state_e st;
    } fsm_regs_t;

    fsm_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        hit   = 1'b0;
        if (tick) begin
            case (cur_q.st)
                ST_IDLE: nxt_d.st = din ? ST_IDLE : ST_Z;
                ST_Z:    nxt_d.st = din ? ST_Z1   : ST_Z;
                ST_Z1:   nxt_d.st = din ? ST_Z11  : ST_Z;
                ST_Z11:  nxt_d.st = din ? ST_Z111 : ST_Z;
                ST_Z111: begin
                    if (din) begin
                        nxt_d.st = ST_IDLE;
                    end else begin
                        nxt_d.st = ST_Z;
                        hit      = 1'b1;
                    end
                end
                default: nxt_d.st = ST_IDLE;
            endcase
        end
        if (rst) begin
            nxt_d.st = ST_IDLE;
            hit      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_STATES; i++) begin
            state_oh[i] = (cur_q.st == pw_state_e'(i));
        end
    end

    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state_oh));

    // R4
    match_next_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> state_oh[1]);

endmodule

// File: rtl/pw_hold.sv
module pw_hold #(
    parameter int HOLD_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    output logic flag
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] FULL = HW'(HOLD_TICKS);

    typedef struct packed {
        logic [HW-1:0] left;
        logic          flag;
    } hold_regs_t;

    hold_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (hit) begin
            nxt_d.left = FULL;
            nxt_d.flag = 1'b1;
        end else if (tick) begin
            if (cur_q.left != '0) begin
                nxt_d.left = cur_q.left - 1'b1;
            end
            nxt_d.flag = (nxt_d.left != '0);
        end
        if (rst) begin
            nxt_d.left = '0;
            nxt_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign flag = cur_q.flag;

    // R5
    match_raise_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);

    // R6
    hold_restart_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cur_q.left == FULL));

    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hit) |=> $stable(flag));

endmodule

// File: rtl/pattern_watch.sv
module pattern_watch
    import pattern_watch_pkg::*;
#(
    parameter int DIV        = 10000,
    parameter int HOLD_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_btn,
    input  logic       din,
    output logic       match_o,
    output logic [7:0] probe_o
);
    logic                  tick;
    logic                  hit;
    logic [NUM_STATES-1:0] state_oh;

    pw_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst_btn),
        .tick (tick)
    );

    pw_fsm u_fsm (
        .clk      (clk),
        .rst      (rst_btn),
        .tick     (tick),
        .din      (din),
        .state_oh (state_oh),
        .hit      (hit)
    );

    pw_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk  (clk),
        .rst  (rst_btn),
        .tick (tick),
        .hit  (hit),
        .flag (match_o)
    );

    assign probe_o = {rst_btn, match_o, tick, state_oh};

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst_btn |=> (state_oh == 5'b00001) && !match_o);

    // R8
    probe_onehot_chk: assert property (@(posedge clk) disable iff (rst_btn)
        $onehot(probe_o[4:0]));

endmodule

// File: tb/pattern_watch_bench.sv
module pattern_watch_bench;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_btn = 1'b1;
    logic din = 1'b0;
    logic match_o, long_match;
    logic [7:0] probe_o, long_probe;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pattern_watch #(.DIV(DIV), .HOLD_TICKS(2)) u_pattern_watch (
        .clk(clk), .rst_btn(rst_btn), .din(din),
        .match_o(match_o), .probe_o(probe_o)
    );

    pattern_watch #(.DIV(DIV), .HOLD_TICKS(6)) u_long (
        .clk(clk), .rst_btn(rst_btn), .din(din),
        .match_o(long_match), .probe_o(long_probe)
    );

    // {din, long flag, flag, one-hot state}
    localparam logic [7:0] VEC [21] = '{
        8'b1_0_0_00001, 8'b0_0_0_00010, 8'b1_0_0_00100, 8'b1_0_0_01000,
        8'b1_0_0_10000, 8'b0_1_1_00010, 8'b1_1_1_00100, 8'b1_1_0_01000,
        8'b1_1_0_10000, 8'b0_1_1_00010, 8'b0_1_1_00010, 8'b1_1_0_00100,
        8'b1_1_0_01000, 8'b1_1_0_10000, 8'b1_1_0_00001, 8'b0_0_0_00010,
        8'b1_0_0_00100, 8'b0_0_0_00010, 8'b1_0_0_00100, 8'b1_0_0_01000,
        8'b0_0_0_00010
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_btn = 1'b1;
        @(negedge clk);
        chk("R7 state", {27'd0, probe_o[4:0]}, 32'h1);
        chk("R7 flag", {31'd0, match_o}, 32'h0);
        chk("R8 reset bit", {31'd0, probe_o[7]}, 32'h1);
        rst_btn = 1'b0;
    endtask

    task automatic send(input logic b);
        din = b;
        while (!probe_o[5]) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int gap;
        int rises;
        logic prev;
        do_reset();

        // R1: first pulse in the DIV-th cycle, one cycle wide, period DIV
        gap = 1;
        while (!probe_o[5]) begin
            @(negedge clk);
            gap++;
        end
        chk("R1 first tick", gap, DIV);
        @(negedge clk);
        chk("R1 width", {31'd0, probe_o[5]}, 32'h0);
        gap = 1;
        while (!probe_o[5]) begin
            @(negedge clk);
            gap++;
        end
        chk("R1 period", gap, DIV);
        @(negedge clk);

        // R3 R4 R5 R6 table walk
        do_reset();
        for (int i = 0; i < 21; i++) begin
            send(VEC[i][7]);
            chk($sformatf("R3 state step %0d", i), {27'd0, probe_o[4:0]}, {27'd0, VEC[i][4:0]});
            chk($sformatf("R5 flag step %0d", i), {31'd0, match_o}, {31'd0, VEC[i][5]});
            chk($sformatf("R6 long flag step %0d", i), {31'd0, long_match}, {31'd0, VEC[i][6]});
        end

        // R2: din toggles between samples, state must not move
        do_reset();
        for (int k = 0; k < 3; k++) begin
            while (!probe_o[5]) begin
                din = ~din;
                @(negedge clk);
                if (!probe_o[5])
                    chk("R2 state steady", {27'd0, probe_o[4:0]}, 32'h1);
            end
            din = 1'b1;
            @(negedge clk);
            chk("R2 sampled one", {27'd0, probe_o[4:0]}, 32'h1);
        end

        // R4 R7: match then reset while flag held
        do_reset();
        send(0); send(1); send(1); send(1); send(0);
        chk("R4 match", {31'd0, match_o}, 32'h1);
        chk("R8 flag bit", {31'd0, probe_o[6]}, 32'h1);
        do_reset();

        // R9: repeating 0111
        rises = 0;
        prev = 1'b0;
        for (int r = 0; r < 4; r++) begin
            send(0);
            if (match_o && !prev) rises++;
            prev = match_o;
            for (int j = 0; j < 3; j++) begin
                send(1);
                prev = match_o;
            end
        end
        send(0);
        if (match_o && !prev) rises++;
        chk("R9 match count", rises, 4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule